// File: doc/BRIEF.md
# Delayed-Branch Fetch Address Sequencer

This block produces the instruction fetch address for a simple in-order pipeline whose branches are delayed. A branch or jump is reported as resolved during the cycle in which it is fetched. After that, the sequencer keeps fetching the instructions that follow it in memory. The number of those fetches is fixed by `DELAY_SLOTS`, which may be 1, 2 or 3. Only after the last of them has been fetched is the branch target loaded into the fetch address. Each of these delay-slot fetches is flagged. If a trap (an exception or a debug breakpoint or step) lands on one of them, the sequencer reports the address of the branch that owns the slot as the restart point, so a resume re-executes the branch along with its slots. When `DELAY_SLOTS` is 0, there are no slots: a taken branch is followed by one fetch bubble, and then the target is fetched.

A controller with four states drives the sequencer:
- `ST_SEQ`: normal sequential fetching.
- `ST_SLOT`: delay-slot fetches are in progress.
- `ST_BUBBLE`: the single empty cycle of the slot-less variant.
- `ST_HALT`: fetching is parked after a trap, waiting for a resume.

The transitions are:
- `ST_SEQ`→`ST_SLOT` when a branch resolves, taken or not.
- `ST_SEQ`→`ST_BUBBLE` when a branch is taken and there are no slots.
- `ST_SLOT`→`ST_SEQ` on the last slot fetch.
- `ST_BUBBLE`→`ST_SEQ` on the first cycle without a stall.
- `ST_SEQ`→`ST_HALT` and `ST_SLOT`→`ST_HALT` on an accepted trap.
- `ST_HALT`→`ST_SEQ` on resume.

A fetch is accepted in any cycle where `fetch_valid` is high and `stall` is low. Branch-resolve and trap inputs only have an effect in such a cycle.

Top module: `pcseq_top`

## Requirements
- R1: While the synchronous reset is high, and in the first cycle after it is released, the sequencer presents `RESET_VEC` with `fetch_valid`=1, `fetch_in_slot`=0, `halted`=0 and `slot_error`=0.
- R2: An accepted fetch without a branch or trap advances the fetch address by 4 (`INC`) and leaves `fetch_in_slot` at 0.
- R3: With `DELAY_SLOTS`=D≥1, a taken branch at address B is followed by fetches of B+4 … B+4·D with `fetch_in_slot`=1, then by the target with `fetch_in_slot`=0. No address is fetched twice.
- R4: With D≥1, a not-taken branch at B is followed by B+4 … B+4·D marked as slots, then by B+4·(D+1) unmarked.
- R5: With D=0, a taken branch at B is followed by exactly one cycle with `fetch_valid`=0, then by the target. A not-taken branch inserts no bubble.
- R6: While `stall` is high, the fetch address, the slot mark and the number of slot fetches still to come are all frozen. A branch stalled inside its slots still yields exactly D slot fetches.
- R7: A branch resolve accepted during a slot fetch is ignored: the slot sequence and the pending target are unchanged. It sets `slot_error`, which stays set until reset.
- R8: A trap accepted on a slot fetch stops fetching (`halted`=1, `fetch_valid`=0). It sets `restart_pc` to the owning branch address and `restart_in_slot`=1, and these hold until resume.
- R9: A trap accepted outside a slot sets `restart_pc` to the trapped fetch address and `restart_in_slot`=0. If a branch resolve arrives in the same cycle, the trap takes priority and the branch is discarded: no slots are marked and no jump is made.
- R10: While halted, a `resume_valid` pulse makes the next fetch `resume_pc`, unmarked, with any pending target discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| stall | input | 1 | Holds the current fetch; nothing advances |
| fetch_valid | output | 1 | A fetch address is being presented |
| fetch_pc | output | AW | Fetch address |
| fetch_in_slot | output | 1 | Current fetch is a delay-slot instruction |
| br_valid | input | 1 | The current fetch is a branch and its outcome is known |
| br_taken | input | 1 | Resolved branch is taken |
| br_target | input | AW | Resolved branch target |
| trap_req | input | 1 | Exception or debug trap on the current fetch |
| resume_valid | input | 1 | Leave the halted state |
| resume_pc | input | AW | Address to resume fetching from |
| halted | output | 1 | Fetching stopped after a trap |
| restart_pc | output | AW | Address at which the trapped code must restart |
| restart_in_slot | output | 1 | The trap hit a delay-slot fetch |
| slot_error | output | 1 | Sticky: a branch resolved inside a delay slot |

## Verification
The trap capture and the branch controller can both act on one accepted fetch. The bench provokes this in two ways. First, it raises `trap_req` together with `br_valid` on a sequential fetch. It then expects the halt, a restart address equal to the branch itself, and a clean run of unmarked sequential fetches after resuming, which shows the branch was dropped. Second, it traps on the first slot of a taken branch. It then expects the owning branch as the restart address with the in-slot bit set, and after the resume a complete replay of the branch with all of its slots. In every lane, a scoreboard compares each cycle's `fetch_valid`, address and slot mark against a sequence worked out from the requirements.

// File: rtl/pcseq_pkg.sv
package pcseq_pkg;

    typedef enum logic [1:0] {
        ST_SEQ    = 2'd0,
        ST_SLOT   = 2'd1,
        ST_BUBBLE = 2'd2,
        ST_HALT   = 2'd3
    } seq_state_e;

    function automatic int unsigned slot_cnt_width(input int unsigned slots);
        return (slots < 2) ? 1 : $clog2(slots + 1);
    endfunction

endpackage

// File: rtl/pcseq_slot_ctr.sv
module pcseq_slot_ctr #(
    parameter int unsigned SLOTS = 1,
    parameter int unsigned CW    = 1
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic load,
    input  logic dec,
    output logic busy,
    output logic last
);
    localparam logic [CW-1:0] LOADV = CW'(SLOTS);
    localparam logic [CW-1:0] ONE   = CW'(1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= LOADV;
        end else if (dec && (cnt_q != '0)) begin
            cnt_q <= cnt_q - ONE;
        end
    end

    assign busy = (cnt_q != '0);
    assign last = (cnt_q == ONE);

    // R3: the remaining-slot count never exceeds the configured number
    p_cnt_bound_r3: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= LOADV);

    // R6: with no load, clear or decrement the count is frozen
    p_cnt_frozen_r6: assert property (@(posedge clk) disable iff (rst)
        (!clr && !load && !dec) |=> $stable(cnt_q));

endmodule

// File: rtl/pcseq_branch_hold.sv
module pcseq_branch_hold #(
    parameter int unsigned AW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr,
    input  logic          load,
    input  logic [AW-1:0] br_pc,
    input  logic          taken,
    input  logic [AW-1:0] target,
    output logic [AW-1:0] owner_pc,
    output logic          pend_taken,
    output logic [AW-1:0] pend_target
);
    always_ff @(posedge clk) begin
        if (rst || clr) begin
            owner_pc    <= '0;
            pend_taken  <= 1'b0;
            pend_target <= '0;
        end else if (load) begin
            owner_pc    <= br_pc;
            pend_taken  <= taken;
            pend_target <= target;
        end
    end

    // R7: the recorded branch survives anything other than a load or a clear
    p_owner_kept_r7: assert property (@(posedge clk) disable iff (rst)
        (!load && !clr) |=> ($stable(owner_pc) && $stable(pend_target) && $stable(pend_taken)));

    // R10: a clear discards the pending jump
    p_clear_drops_r10: assert property (@(posedge clk) disable iff (rst)
        clr |=> !pend_taken);

endmodule

// File: rtl/pcseq_pc_unit.sv
module pcseq_pc_unit #(
    parameter int unsigned  AW        = 32,
    parameter logic [AW-1:0] RESET_VEC = '0,
    parameter int unsigned  INC       = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          resume,
    input  logic [AW-1:0] resume_pc,
    input  logic          advance,
    input  logic          jump,
    input  logic [AW-1:0] jump_pc,
    output logic [AW-1:0] pc
);
    localparam logic [AW-1:0] STEP = AW'(INC);

    logic [AW-1:0] pc_q;
    logic [AW-1:0] pc_d;

    always_comb begin
        pc_d = pc_q;
        if (resume) begin
            pc_d = resume_pc;
        end else if (advance) begin
            pc_d = jump ? jump_pc : (pc_q + STEP);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pc_q <= RESET_VEC;
        end else begin
            pc_q <= pc_d;
        end
    end

    assign pc = pc_q;

    // R6: without advance or resume the address does not move
    p_pc_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (!resume && !advance) |=> $stable(pc_q));

endmodule

// File: rtl/pcseq_trap_cap.sv
module pcseq_trap_cap #(
    parameter int unsigned AW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          capture,
    input  logic          in_slot,
    input  logic [AW-1:0] cur_pc,
    input  logic [AW-1:0] owner_pc,
    output logic [AW-1:0] restart_pc,
    output logic          restart_in_slot
);
    always_ff @(posedge clk) begin
        if (rst) begin
            restart_pc      <= '0;
            restart_in_slot <= 1'b0;
        end else if (capture) begin
            restart_pc      <= in_slot ? owner_pc : cur_pc;
            restart_in_slot <= in_slot;
        end
    end

    // R8: a slot trap restarts at the branch that owns the slot
    p_slot_restart_r8: assert property (@(posedge clk) disable iff (rst)
        (capture && in_slot) |=> (restart_in_slot && (restart_pc == $past(owner_pc))));

    // R9: a trap outside a slot restarts at the trapped fetch
    p_plain_restart_r9: assert property (@(posedge clk) disable iff (rst)
        (capture && !in_slot) |=> (!restart_in_slot && (restart_pc == $past(cur_pc))));

endmodule

// File: rtl/pcseq_top.sv
module pcseq_top
    import pcseq_pkg::*;
#(
    parameter int unsigned   AW          = 32,
    parameter int unsigned   DELAY_SLOTS = 1,
    parameter logic [AW-1:0] RESET_VEC   = 'h1000,
    parameter int unsigned   INC         = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          stall,
    output logic          fetch_valid,
    output logic [AW-1:0] fetch_pc,
    output logic          fetch_in_slot,
    input  logic          br_valid,
    input  logic          br_taken,
    input  logic [AW-1:0] br_target,
    input  logic          trap_req,
    input  logic          resume_valid,
    input  logic [AW-1:0] resume_pc,
    output logic          halted,
    output logic [AW-1:0] restart_pc,
    output logic          restart_in_slot,
    output logic          slot_error
);
    localparam int unsigned   CW        = slot_cnt_width(DELAY_SLOTS);
    localparam bit            HAS_SLOTS = (DELAY_SLOTS != 0);
    localparam logic [AW-1:0] STEP      = AW'(INC);

    seq_state_e    state_q;
    seq_state_e    state_d;
    logic          accept;
    logic          trap_acc;
    logic          br_acc_seq;
    logic          br_in_slot;
    logic          slot_fetch;
    logic          slot_exit;
    logic          advance;
    logic          resume_go;
    logic          jump;
    logic [AW-1:0] jump_pc;
    logic          ctr_load;
    logic          ctr_busy;
    logic          ctr_last;
    logic          hold_clr;
    logic [AW-1:0] owner_pc;
    logic          pend_taken;
    logic [AW-1:0] pend_target;
    logic          err_q;

    // ---------------- qualified events ----------------
    assign accept     = fetch_valid && !stall;
    assign trap_acc   = accept && trap_req;
    assign advance    = accept && !trap_req;
    assign br_acc_seq = advance && br_valid && (state_q == ST_SEQ);
    assign br_in_slot = accept && br_valid && (state_q == ST_SLOT);
    assign slot_fetch = advance && (state_q == ST_SLOT);
    assign slot_exit  = slot_fetch && ctr_last;
    assign resume_go  = (state_q == ST_HALT) && resume_valid;
    assign hold_clr   = trap_acc || resume_go;

    // ---------------- variant: delay slots or a bubble ----------------
    generate
        if (HAS_SLOTS) begin : g_slots
            assign ctr_load = br_acc_seq;
            assign jump     = slot_exit && pend_taken;
            assign jump_pc  = pend_target;
        end else begin : g_bubble
            assign ctr_load = 1'b0;
            assign jump     = br_acc_seq && br_taken;
            assign jump_pc  = br_target;
        end
    endgenerate

    // ---------------- state register ----------------
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_SEQ;
        end else begin
            state_q <= state_d;
        end
    end

    // ---------------- next state ----------------
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_SEQ: begin
                if (trap_acc) begin
                    state_d = ST_HALT;
                end else if (br_acc_seq) begin
                    if (HAS_SLOTS) begin
                        state_d = ST_SLOT;
                    end else if (br_taken) begin
                        state_d = ST_BUBBLE;
                    end
                end
            end
            ST_SLOT: begin
                if (trap_acc) begin
                    state_d = ST_HALT;
                end else if (slot_exit) begin
                    state_d = ST_SEQ;
                end
            end
            ST_BUBBLE: begin
                if (!stall) begin
                    state_d = ST_SEQ;
                end
            end
            ST_HALT: begin
                if (resume_valid) begin
                    state_d = ST_SEQ;
                end
            end
            default: state_d = ST_SEQ;
        endcase
    end

    // ---------------- outputs from state ----------------
    always_comb begin
        fetch_valid   = 1'b0;
        fetch_in_slot = 1'b0;
        halted        = 1'b0;
        unique case (state_q)
            ST_SEQ:    fetch_valid = 1'b1;
            ST_SLOT: begin
                fetch_valid   = 1'b1;
                fetch_in_slot = 1'b1;
            end
            ST_BUBBLE: fetch_valid = 1'b0;
            ST_HALT:   halted = 1'b1;
            default:   fetch_valid = 1'b0;
        endcase
    end

    // ---------------- sticky misuse flag ----------------
    always_ff @(posedge clk) begin
        if (rst) begin
            err_q <= 1'b0;
        end else if (br_in_slot) begin
            err_q <= 1'b1;
        end
    end
    assign slot_error = err_q;

    // ---------------- datapath pieces ----------------
    pcseq_pc_unit #(
        .AW        (AW),
        .RESET_VEC (RESET_VEC),
        .INC       (INC)
    ) u_pc (
        .clk       (clk),
        .rst       (rst),
        .resume    (resume_go),
        .resume_pc (resume_pc),
        .advance   (advance),
        .jump      (jump),
        .jump_pc   (jump_pc),
        .pc        (fetch_pc)
    );

    pcseq_slot_ctr #(
        .SLOTS (DELAY_SLOTS),
        .CW    (CW)
    ) u_ctr (
        .clk  (clk),
        .rst  (rst),
        .clr  (trap_acc),
        .load (ctr_load),
        .dec  (slot_fetch),
        .busy (ctr_busy),
        .last (ctr_last)
    );

    pcseq_branch_hold #(
        .AW (AW)
    ) u_hold (
        .clk         (clk),
        .rst         (rst),
        .clr         (hold_clr),
        .load        (br_acc_seq),
        .br_pc       (fetch_pc),
        .taken       (br_taken),
        .target      (br_target),
        .owner_pc    (owner_pc),
        .pend_taken  (pend_taken),
        .pend_target (pend_target)
    );

    pcseq_trap_cap #(
        .AW (AW)
    ) u_trap (
        .clk             (clk),
        .rst             (rst),
        .capture         (trap_acc),
        .in_slot         (fetch_in_slot),
        .cur_pc          (fetch_pc),
        .owner_pc        (owner_pc),
        .restart_pc      (restart_pc),
        .restart_in_slot (restart_in_slot)
    );

    // ---------------- assertions ----------------
    // R2: plain sequential step
    p_seq_step_r2: assert property (@(posedge clk) disable iff (rst)
        ((state_q == ST_SEQ) && accept && !trap_req && !br_valid)
            |=> (fetch_pc == $past(fetch_pc) + STEP));

    // R6: a stall freezes the visible fetch
    p_stall_freeze_r6: assert property (@(posedge clk) disable iff (rst)
        (stall && !halted) |=> ($stable(fetch_pc) && $stable(fetch_in_slot) && $stable(fetch_valid)));

    // R7: the misuse flag never drops before reset
    p_err_sticky_r7: assert property (@(posedge clk) disable iff (rst)
        slot_error |=> slot_error);

    // R8: halted stays parked until a resume arrives
    p_halt_park_r8: assert property (@(posedge clk) disable iff (rst)
        (halted && !resume_valid) |=> (halted && !fetch_valid && $stable(restart_pc)));

    // R10: resume fetches the given address, unmarked
    p_resume_r10: assert property (@(posedge clk) disable iff (rst)
        (halted && resume_valid)
            |=> (fetch_valid && !fetch_in_slot && (fetch_pc == $past(resume_pc))));

    generate
        if (HAS_SLOTS) begin : g_chk_slots
            // R3: the fetch after an accepted branch is a marked slot
            p_slot_follow_r3: assert property (@(posedge clk) disable iff (rst)
                br_acc_seq |=> fetch_in_slot);
            // R3: the slot state and the counter agree
            p_slot_ctr_r3: assert property (@(posedge clk) disable iff (rst)
                fetch_in_slot |-> ctr_busy);
        end else begin : g_chk_bubble
            // R5: a taken branch is followed by an empty cycle
            p_bubble_r5: assert property (@(posedge clk) disable iff (rst)
                (br_acc_seq && br_taken) |=> !fetch_valid);
        end
    endgenerate

endmodule

// File: tb/sim_pcseq_lane.sv
`timescale 1ns/100ps
module sim_pcseq_lane #(
    parameter int unsigned DS = 1
) (
    input  logic clk,
    output int   n_chk,
    output int   n_err,
    output logic done
);
    logic        rst;
    logic        stall;
    logic        fetch_valid;
    logic [31:0] fetch_pc;
    logic        fetch_in_slot;
    logic        br_valid;
    logic        br_taken;
    logic [31:0] br_target;
    logic        trap_req;
    logic        resume_valid;
    logic [31:0] resume_pc;
    logic        halted;
    logic [31:0] restart_pc;
    logic        restart_in_slot;
    logic        slot_error;

    pcseq_top #(
        .AW          (32),
        .DELAY_SLOTS (DS),
        .RESET_VEC   (32'h0000_1000),
        .INC         (4)
    ) u0 (
        .clk             (clk),
        .rst             (rst),
        .stall           (stall),
        .fetch_valid     (fetch_valid),
        .fetch_pc        (fetch_pc),
        .fetch_in_slot   (fetch_in_slot),
        .br_valid        (br_valid),
        .br_taken        (br_taken),
        .br_target       (br_target),
        .trap_req        (trap_req),
        .resume_valid    (resume_valid),
        .resume_pc       (resume_pc),
        .halted          (halted),
        .restart_pc      (restart_pc),
        .restart_in_slot (restart_in_slot),
        .slot_error      (slot_error)
    );

    typedef struct {
        logic        fv;
        logic [31:0] pc;
        logic        slot;
        string       rq;
    } exp_t;

    exp_t        q[$];
    int          chk_n = 0;
    int          err_n = 0;
    logic [31:0] exp_pc;

    assign n_chk = chk_n;
    assign n_err = err_n;

    task automatic expect_eq(input string rq, input string what,
                             input logic [31:0] act, input logic [31:0] expv);
        chk_n++;
        if (act !== expv) begin
            err_n++;
            $display("FAIL %s DS=%0d %s actual=%h expected=%h", rq, DS, what, act, expv);
        end
    endtask

    // monitor: one expected item per cycle
    initial begin
        forever begin
            @(negedge clk);
            #1;
            if (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                expect_eq(e.rq, "fetch_valid", {31'd0, fetch_valid}, {31'd0, e.fv});
                if (e.fv) begin
                    expect_eq(e.rq, "fetch_pc", fetch_pc, e.pc);
                    expect_eq(e.rq, "fetch_in_slot", {31'd0, fetch_in_slot}, {31'd0, e.slot});
                end
            end
        end
    end

    task automatic step(input bit brv, input bit tk, input logic [31:0] tg,
                        input bit stl, input bit trp, input bit rsv, input logic [31:0] rp,
                        input bit efv, input logic [31:0] epc, input bit esl, input string rq);
        exp_t e;
        br_valid     = brv;
        br_taken     = tk;
        br_target    = tg;
        stall        = stl;
        trap_req     = trp;
        resume_valid = rsv;
        resume_pc    = rp;
        e.fv = efv; e.pc = epc; e.slot = esl; e.rq = rq;
        q.push_back(e);
        @(negedge clk);
    endtask

    task automatic run_seq(input int n, input string rq);
        for (int i = 0; i < n; i++) begin
            step(0, 0, 32'd0, 0, 0, 0, 32'd0, 1, exp_pc, 0, rq);
            exp_pc += 32'd4;
        end
    endtask

    task automatic stall_seq(input int n);
        for (int i = 0; i < n; i++) begin
            step(0, 0, 32'd0, 1, 0, 0, 32'd0, 1, exp_pc, 0, "R6");
        end
    endtask

    // a branch at exp_pc; optional stall inside slot number stall_at; optional
    // illegal branch resolve on the first slot
    task automatic branch(input bit tk, input logic [31:0] tg, input int stall_at,
                          input bit bad_br, input string rq);
        step(1, tk, tg, 0, 0, 0, 32'd0, 1, exp_pc, 0, rq);
        exp_pc += 32'd4;
        if (DS == 0) begin
            if (tk) begin
                step(0, 0, 32'd0, 0, 0, 0, 32'd0, 0, 32'd0, 0, "R5");
            end
        end else begin
            for (int i = 1; i <= int'(DS); i++) begin
                if (i == stall_at) begin
                    step(0, 0, 32'd0, 1, 0, 0, 32'd0, 1, exp_pc, 1, "R6");
                    step(0, 0, 32'd0, 1, 0, 0, 32'd0, 1, exp_pc, 1, "R6");
                end
                if (bad_br && i == 1) begin
                    step(1, 1, 32'hDEAD_0000, 0, 0, 0, 32'd0, 1, exp_pc, 1, "R7");
                end else begin
                    step(0, 0, 32'd0, 0, 0, 0, 32'd0, 1, exp_pc, 1, rq);
                end
                exp_pc += 32'd4;
            end
        end
        if (tk) exp_pc = tg;
    endtask

    initial begin
        logic [31:0] owner;
        done         = 1'b0;
        rst          = 1'b1;
        stall        = 1'b0;
        br_valid     = 1'b0;
        br_taken     = 1'b0;
        br_target    = '0;
        trap_req     = 1'b0;
        resume_valid = 1'b0;
        resume_pc    = '0;
        repeat (3) @(negedge clk);
        expect_eq("R1", "reset pc", fetch_pc, 32'h0000_1000);
        rst = 1'b0;
        expect_eq("R1", "reset fetch_valid", {31'd0, fetch_valid}, 32'd1);
        expect_eq("R1", "reset slot", {31'd0, fetch_in_slot}, 32'd0);
        expect_eq("R1", "reset halted", {31'd0, halted}, 32'd0);
        expect_eq("R1", "reset error", {31'd0, slot_error}, 32'd0);
        exp_pc = 32'h0000_1000;

        run_seq(3, "R2");
        branch(1, 32'h0000_2000, 0, 0, (DS == 0) ? "R5" : "R3");
        run_seq(2, "R3");
        stall_seq(2);
        run_seq(1, "R2");
        branch(0, 32'h0000_3000, 0, 0, "R4");
        run_seq(2, "R4");
        branch(1, 32'h0000_4000, (DS >= 2) ? 2 : 1, 0, "R6");
        run_seq(2, "R6");
        expect_eq("R7", "no error on legal branches", {31'd0, slot_error}, 32'd0);

        if (DS > 0) begin
            // R7: illegal branch inside a slot is ignored and flagged
            branch(1, 32'h0000_5000, 0, 1, "R7");
            run_seq(2, "R7");
            expect_eq("R7", "error flag set", {31'd0, slot_error}, 32'd1);

            // R8: trap on the first slot of a taken branch
            owner = exp_pc;
            step(1, 1, 32'h0000_6000, 0, 0, 0, 32'd0, 1, exp_pc, 0, "R8");
            exp_pc += 32'd4;
            step(0, 0, 32'd0, 0, 1, 0, 32'd0, 1, exp_pc, 1, "R8");
            step(0, 0, 32'd0, 0, 0, 0, 32'd0, 0, 32'd0, 0, "R8");
            expect_eq("R8", "halted", {31'd0, halted}, 32'd1);
            expect_eq("R8", "restart at owner", restart_pc, owner);
            expect_eq("R8", "restart in slot", {31'd0, restart_in_slot}, 32'd1);
            step(0, 0, 32'd0, 0, 0, 1, owner, 0, 32'd0, 0, "R10");
            exp_pc = owner;
            branch(1, 32'h0000_6000, 0, 0, "R10");
            run_seq(2, "R10");
        end

        // R9: trap and branch resolve on the same sequential fetch
        owner = exp_pc;
        step(1, 1, 32'h0000_7000, 0, 1, 0, 32'd0, 1, exp_pc, 0, "R9");
        step(0, 0, 32'd0, 0, 0, 0, 32'd0, 0, 32'd0, 0, "R9");
        expect_eq("R9", "restart at trapped fetch", restart_pc, owner);
        expect_eq("R9", "restart not in slot", {31'd0, restart_in_slot}, 32'd0);
        step(0, 0, 32'd0, 0, 0, 1, owner, 0, 32'd0, 0, "R10");
        exp_pc = owner;
        run_seq(4, "R9");
        expect_eq("R7", "error flag sticky", {31'd0, slot_error}, (DS > 0) ? 32'd1 : 32'd0);

        step(0, 0, 32'd0, 0, 0, 0, 32'd0, 1, exp_pc, 0, "R2");
        #2;
        done = 1'b1;
    end

endmodule

// File: tb/sim_pcseq_top.sv
`timescale 1ns/100ps
module sim_pcseq_top;
    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    int   chk0, chk1, chk2, chk3;
    int   err0, err1, err2, err3;
    logic dn0, dn1, dn2, dn3;

    sim_pcseq_lane #(.DS(0)) u_l0 (.clk(clk), .n_chk(chk0), .n_err(err0), .done(dn0));
    sim_pcseq_lane #(.DS(1)) u_l1 (.clk(clk), .n_chk(chk1), .n_err(err1), .done(dn1));
    sim_pcseq_lane #(.DS(2)) u_l2 (.clk(clk), .n_chk(chk2), .n_err(err2), .done(dn2));
    sim_pcseq_lane #(.DS(3)) u_l3 (.clk(clk), .n_chk(chk3), .n_err(err3), .done(dn3));

    initial begin
        int cyc;
        int total_err;
        int total_chk;
        cyc = 0;
        while (!(dn0 === 1'b1 && dn1 === 1'b1 && dn2 === 1'b1 && dn3 === 1'b1) && cyc < 20000) begin
            @(posedge clk);
            cyc++;
        end
        #1;
        total_err = err0 + err1 + err2 + err3;
        total_chk = chk0 + chk1 + chk2 + chk3;
        if (cyc >= 20000) begin
            total_err++;
            total_chk++;
            $display("FAIL watchdog: run did not complete, actual=%0d cycles expected<20000", cyc);
        end
        $display("Result: errors=%0d of %0d checks", total_err, total_chk);
        $finish;
    end
endmodule